// File: doc/BRIEF.md
# Transmit Buffer with Underrun Replay

This block is the outgoing word store of a synchronous serial port. A processor-side write port loads 16-bit words into an eight-slot circular store. A pop strobe is raised by the shift logic each time it takes a word to send. When the FIFO holds data, pops hand the words out in the order they were written.

When the port acts as a slave, the external master decides when a frame starts, so a word must be available even if the buffer has run dry. On such an underrun the block presents the word that was accepted eight writes before the present moment. If fewer than eight words have been accepted since the module was last enabled, it presents zero. An underrun moves no pointer. In master mode an empty buffer presents zero and a pop is ignored.

Status outputs show empty, full, not-full and below-half levels, so that an interrupt or DMA request can be raised. A sticky flag records any write that was refused.

Top module: `sio_tx_fifo`

## Requirements
- R1: While `en` is low, the block is held cleared: `empty`=1, `full`=0, `not_full`=1, `below_half`=1, `overflow`=0, and the write history is forgotten.
- R2: Accepted words leave in write order. While `empty`=0, `rd_data` shows the oldest stored word, and a pop removes it.
- R3: `full`=1 exactly when 8 words are stored, and `empty`=1 exactly when none are stored. `not_full` is the inverse of `full`.
- R4: A write while full, with no pop in the same cycle, is dropped: the contents are unchanged and `overflow` becomes 1. It stays 1 until `en` goes low.
- R5: A write and a pop in the same cycle are both honoured. When the buffer is full, the level stays at 8 and the new word is queued.
- R6: In slave mode (`slave_mode`=1), when the buffer is empty and at least 8 words have been accepted since enable, `rd_data` equals the eighth most recently accepted word. A pop then leaves the buffer empty and the same word stays presented.
- R7: In slave mode with the buffer empty and fewer than 8 accepted words since enable, `rd_data` is 0.
- R8: In master mode (`slave_mode`=0) with the buffer empty, `rd_data` is 0 and a pop has no effect.
- R9: `below_half`=1 exactly when fewer than 4 words are stored.
- R10: After `en` falls and rises again, words accepted before the fall do not count toward the 8 that R6 needs. Underruns return 0 until 8 new words have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable; low clears the block |
| slave_mode | input | 1 | 1 = slave (replay on underrun), 0 = master |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 16 | Word to store |
| pop | input | 1 | Shift logic takes a word |
| rd_data | output | 16 | Word presented to the shift logic |
| empty | output | 1 | No word stored |
| full | output | 1 | 8 words stored |
| not_full | output | 1 | Inverse of full |
| below_half | output | 1 | Fewer than 4 words stored |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
A wrong pointer shows up at the first pop after it, as a word out of order on `rd_data`. A wrong level shows up within one cycle on `empty`, `full` or `below_half`. A write-history counter that is off shows up only at an underrun: it presents zero where a replay is due, or the reverse. For this reason the sequence places underruns on both sides of the eighth write and again after re-enabling. A replay slot that is off by one shows up as a word from the wrong write generation.

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slave_mode,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             not_full,
  output logic             below_half,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_HALF = LW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [LW-1:0]    level, hist_cnt;
  logic             pop_ok, wr_ok, replay_ok;

  assign empty      = (level == '0);
  assign full       = (level == LVL_FULL);
  assign not_full   = ~full;
  assign below_half = (level < LVL_HALF);
  assign pop_ok     = pop & ~empty;
  assign wr_ok      = wr_en & (~full | pop_ok);
  assign replay_ok  = (hist_cnt == LVL_FULL);

  always_comb begin
    if (!empty)                      rd_data = mem[rptr];
    else if (slave_mode && replay_ok) rd_data = mem[wptr];
    else                             rd_data = '0;
  end

  always_ff @(posedge clk)
    if (en && wr_ok) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0; hist_cnt <= '0; overflow <= 1'b0;
    end else if (!en) begin
      wptr <= '0; rptr <= '0; level <= '0; hist_cnt <= '0; overflow <= 1'b0;
    end else begin
      if (wr_ok)  wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop_ok) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      if (wr_ok && !pop_ok)      level <= level + 1'b1;
      else if (!wr_ok && pop_ok) level <= level - 1'b1;
      if (wr_ok && !replay_ok) hist_cnt <= hist_cnt + 1'b1;
      if (wr_en && !wr_ok) overflow <= 1'b1;
    end
  end
endmodule

module sio_tx_fifo_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             slave_mode,
  input logic             wr_en,
  input logic             pop,
  input logic [WIDTH-1:0] rd_data,
  input logic             empty,
  input logic             full,
  input logic             not_full,
  input logic             below_half,
  input logic             overflow
);
  // R1
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (empty && !full && below_half && !overflow));
  // R3
  full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!not_full && !empty));
  // R4
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && full && !pop) |=> (overflow && full));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && overflow) |=> overflow);
  // R5
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && wr_en && pop) |=> full);
  // R6
  underrun_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && empty && pop && !wr_en) |=> empty);
  // R8
  master_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !slave_mode) |-> (rd_data == '0));
  // R9
  half_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !below_half);
endmodule

bind sio_tx_fifo sio_tx_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode), .wr_en(wr_en),
  .pop(pop), .rd_data(rd_data), .empty(empty), .full(full), .not_full(not_full),
  .below_half(below_half), .overflow(overflow));

// File: tb/tb_sio_tx_fifo.sv
`timescale 1ns/1ps
module tb_sio_tx_fifo;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, slave_mode = 1'b1;
  logic wr_en = 1'b0, pop = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic empty, full, not_full, below_half, overflow;

  int n_run = 0, n_fail = 0;
  logic [15:0] fq[$], hist[$], exp_q[$];
  int wcnt = 0;
  bit ovf_m = 0;

  sio_tx_fifo dut (.clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode),
    .wr_en(wr_en), .wr_data(wr_data), .pop(pop), .rd_data(rd_data), .empty(empty),
    .full(full), .not_full(not_full), .below_half(below_half), .overflow(overflow));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic flags(string tag);
    chk({tag, " empty"}, empty, fq.size() == 0);
    chk({tag, " full"}, full, fq.size() == 8);
    chk({tag, " not_full"}, not_full, fq.size() != 8);
    chk("R9 below_half", below_half, fq.size() < 4);
    chk("R4 overflow", overflow, ovf_m);
  endtask

  // monitor: pops an expected word and compares with the design output
  task automatic monitor(string tag);
    logic [15:0] e;
    e = exp_q.pop_front();
    chk(tag, rd_data, e);
  endtask

  // driver: one cycle of stimulus, expected item queued, model updated
  task automatic cycle(bit w, logic [15:0] d, bit p);
    bit pe, acc;
    string tag;
    @(negedge clk);
    wr_en = w; wr_data = d; pop = p;
    #1;
    if (p && en) begin
      if (fq.size() > 0) begin exp_q.push_back(fq[0]); tag = "R2 pop order"; end
      else if (!slave_mode) begin exp_q.push_back(16'h0); tag = "R8 master empty"; end
      else if (wcnt >= 8) begin exp_q.push_back(hist[0]); tag = "R6 replay"; end
      else begin exp_q.push_back(16'h0); tag = "R7 zero underrun"; end
      monitor(tag);
    end
    if (en) begin
      pe  = p && fq.size() > 0;
      acc = w && (fq.size() < 8 || pe);
      if (fq.size() == 8 && w && p) tag = "R5 full swap";
      else tag = "R3";
      if (pe) void'(fq.pop_front());
      if (acc) begin
        fq.push_back(d); hist.push_back(d); wcnt++;
        if (hist.size() > 8) void'(hist.pop_front());
      end
      if (w && !acc) ovf_m = 1;
    end else begin
      fq.delete(); hist.delete(); wcnt = 0; ovf_m = 0; tag = "R1";
    end
    @(posedge clk); #1;
    wr_en = 0; pop = 0;
    flags(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cycle(1, 16'hdead, 0);
    flags("R1 disabled");
    en = 1'b1;
    cycle(0, 0, 1);
    for (int i = 0; i < 3; i++) cycle(1, 16'h1000 + 16'(i), 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1);
    cycle(0, 0, 1);
    for (int i = 0; i < 10; i++) cycle(1, 16'h2000 + 16'(i), 0);
    cycle(1, 16'h3000, 1);
    cycle(1, 16'h3001, 1);
    for (int i = 0; i < 8; i++) cycle(0, 0, 1);
    for (int i = 0; i < 3; i++) cycle(0, 0, 1);
    cycle(1, 16'h4000, 1);
    cycle(0, 0, 1);
    cycle(0, 0, 1);
    slave_mode = 1'b0;
    cycle(0, 0, 1);
    cycle(0, 0, 1);
    slave_mode = 1'b1;
    cycle(0, 0, 1);
    // R10: disable then re-enable forgets history
    en = 1'b0;
    cycle(0, 0, 0);
    en = 1'b1;
    cycle(0, 0, 1);
    for (int i = 0; i < 7; i++) begin cycle(1, 16'h5000 + 16'(i), 0); cycle(0, 0, 1); end
    cycle(0, 0, 1);
    cycle(1, 16'h5007, 0);
    cycle(0, 0, 1);
    cycle(0, 0, 1);
    chk("R10 replay after 8 new", rd_data, 16'h5000);
    for (int i = 0; i < 5; i++) cycle(1, 16'h6000 + 16'(i), 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule